// File: doc/BRIEF.md
# Minority-Clique Shutdown Guard

This block sits beside the frame checker of a node in a time-slotted cluster. Every received slot ends with a verdict from the checker: the frame's check sequence agreed with the locally computed one, it disagreed, or nothing arrived. Because the local value includes the node's view of cluster membership, a frame from a node holding a different membership view shows up as a disagreement. The guard keeps two competing tallies, one of agreeing frames and one of disagreeing frames. Each tally saturates at a parameterised cluster size instead of wrapping.

When the node reaches its own sending slot, the guard compares the two tallies. If agreements strictly outnumber disagreements, the node belongs to the majority. The guard grants one cycle of send permission and starts a fresh round with the agreeing tally at 1, which stands for the node's own frame, and the disagreeing tally at 0. Otherwise the node is in the minority and freezes. The freeze holds until an external restart. During the freeze send permission stays low and every slot verdict is ignored. Because of this scheme, a node on the losing side of a split falls silent within two slot rounds.

Top module: `clique_guard`

## Requirements
- R1: After reset the agree tally is 1, the disagree tally is 0, and both send permission and freeze are low.
- R2: A slot strobe carrying result code 2'b01 (agreement) raises the agree tally by one on the next cycle, when the node is live and not in its own slot.
- R3: A slot strobe carrying result code 2'b10 (disagreement) raises the disagree tally by one on the next cycle, under the same conditions.
- R4: Result codes 2'b00 and 2'b11 (no frame) leave both tallies unchanged, as does a cycle without a slot strobe.
- R5: Neither tally ever exceeds CLUSTER_MAX. An increment at CLUSTER_MAX leaves the tally at CLUSTER_MAX.
- R6: On an own-slot strobe with agree > disagree, send permission is high in the next cycle only, and the tallies become 1 and 0.
- R7: On an own-slot strobe with disagree >= agree, freeze is set in the next cycle, send permission stays low, and the tallies keep their values.
- R8: While frozen and without restart, the tallies hold, send permission stays low and freeze stays set, whatever slot, own-slot or result inputs arrive.
- R9: Restart clears freeze and sets the tallies to 1 and 0 in the next cycle. It overrides a simultaneous own-slot strobe, so send permission stays low.
- R10: When a slot strobe and an own-slot strobe arrive in the same cycle, the slot result is discarded and the verdict uses the tallies as they stood.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| restart_i | input | 1 | Leave the freeze and start afresh |
| slot_i | input | 1 | Strobe: a received slot's check result is valid |
| own_slot_i | input | 1 | Strobe: decide now, before the node's own transmission |
| result_i | input | 2 | Check result: 01 agree, 10 disagree, 00/11 no frame |
| send_ok_o | output | 1 | One-cycle permission to transmit |
| frozen_o | output | 1 | Node is shut down as a minority member |
| accept_cnt_o | output | $clog2(CLUSTER_MAX+1) | Agree tally |
| reject_cnt_o | output | $clog2(CLUSTER_MAX+1) | Disagree tally |

## Verification
Two functions can fall in the same cycle. One is the own-slot verdict, which meets a received-slot result or a restart. The other is the tally update. The bench provokes the verdict clash on purpose. It places a disagreement just before an own slot that carries an agreement, so the tallies tie at 1 and 1; if the carried agreement were counted, the node would win. It also places an agreement before an own slot that carries a disagreement, and it raises restart together with an own slot while frozen. Each case is judged on the permission, freeze and tally outputs one cycle later. The random phase keeps producing such collisions against the bench's own model.

// File: rtl/clique_guard_pkg.sv
package clique_guard_pkg;

    typedef enum logic [1:0] {
        RES_NONE     = 2'b00,
        RES_AGREE    = 2'b01,
        RES_DISAGREE = 2'b10,
        RES_VOID     = 2'b11
    } slot_res_e;

    typedef struct packed {
        logic frozen;
        logic send_ok;
    } guard_state_t;

    localparam int unsigned TALLY_AGREE    = 0;
    localparam int unsigned TALLY_DISAGREE = 1;
    localparam int unsigned TALLY_NUM      = 2;

endpackage

// File: rtl/cg_slot_decode.sv
module cg_slot_decode
    import clique_guard_pkg::*;
(
    input  logic       live_i,
    input  logic       slot_i,
    input  logic       own_slot_i,
    input  logic [1:0] result_i,
    output logic [TALLY_NUM-1:0] inc_o
);

    logic take;

    always_comb begin
        // the own slot carries no received frame: any result is dropped (R10)
        take  = live_i && slot_i && !own_slot_i;
        inc_o = '0;
        if (take) begin
            unique case (slot_res_e'(result_i))
                RES_AGREE:    inc_o[TALLY_AGREE]    = 1'b1;
                RES_DISAGREE: inc_o[TALLY_DISAGREE] = 1'b1;
                default:      inc_o                 = '0;
            endcase
        end
    end

endmodule

// File: rtl/cg_sat_count.sv
module cg_sat_count #(
    parameter int unsigned MAX  = 32,
    parameter int unsigned W    = 6,
    parameter int unsigned INIT = 0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);

    localparam logic [W-1:0] TOP   = W'(MAX);
    localparam logic [W-1:0] START = W'(INIT);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = START;
        end else if (inc_i && (cnt_q < TOP)) begin
            cnt_d = cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= START;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;

    p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= TOP);

    p_sat_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (inc_i && !clr_i && cnt_q == TOP) |=> (cnt_q == TOP));

endmodule

// File: rtl/cg_verdict.sv
module cg_verdict #(
    parameter int unsigned W = 6
) (
    input  logic [W-1:0] agree_i,
    input  logic [W-1:0] disagree_i,
    output logic         win_o
);

    // strict majority only: a tie counts as minority
    always_comb begin
        win_o = (agree_i > disagree_i);
    end

endmodule

// File: rtl/clique_guard.sv
module clique_guard
    import clique_guard_pkg::*;
#(
    parameter int unsigned CLUSTER_MAX = 32
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       restart_i,
    input  logic       slot_i,
    input  logic       own_slot_i,
    input  logic [1:0] result_i,
    output logic       send_ok_o,
    output logic       frozen_o,
    output logic [$clog2(CLUSTER_MAX+1)-1:0] accept_cnt_o,
    output logic [$clog2(CLUSTER_MAX+1)-1:0] reject_cnt_o
);

    localparam int unsigned CNT_W = $clog2(CLUSTER_MAX + 1);

    guard_state_t state_d, state_q;

    logic                 live;
    logic                 decide;
    logic                 win;
    logic                 clr;
    logic [TALLY_NUM-1:0] inc;
    logic [CNT_W-1:0]     tally [TALLY_NUM];

    assign live   = !state_q.frozen && !restart_i;
    assign decide = live && own_slot_i;
    assign clr    = restart_i || (decide && win);

    cg_slot_decode i_decode (
        .live_i     (live),
        .slot_i     (slot_i),
        .own_slot_i (own_slot_i),
        .result_i   (result_i),
        .inc_o      (inc)
    );

    for (genvar g = 0; g < TALLY_NUM; g++) begin : g_tally
        cg_sat_count #(
            .MAX  (CLUSTER_MAX),
            .W    (CNT_W),
            .INIT ((g == TALLY_AGREE) ? 1 : 0)
        ) i_count (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .clr_i  (clr),
            .inc_i  (inc[g]),
            .cnt_o  (tally[g])
        );
    end

    cg_verdict #(.W(CNT_W)) i_verdict (
        .agree_i    (tally[TALLY_AGREE]),
        .disagree_i (tally[TALLY_DISAGREE]),
        .win_o      (win)
    );

    always_comb begin
        state_d         = state_q;
        state_d.send_ok = 1'b0;
        if (restart_i) begin
            state_d.frozen = 1'b0;
        end else if (decide) begin
            if (win) begin
                state_d.send_ok = 1'b1;
            end else begin
                state_d.frozen = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '{frozen: 1'b0, send_ok: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    assign send_ok_o    = state_q.send_ok;
    assign frozen_o     = state_q.frozen;
    assign accept_cnt_o = tally[TALLY_AGREE];
    assign reject_cnt_o = tally[TALLY_DISAGREE];

    p_agree_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (live && slot_i && !own_slot_i && result_i == 2'b01 && accept_cnt_o < CNT_W'(CLUSTER_MAX))
        |=> (accept_cnt_o == $past(accept_cnt_o) + CNT_W'(1)) && $stable(reject_cnt_o));

    p_disagree_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (live && slot_i && !own_slot_i && result_i == 2'b10 && reject_cnt_o < CNT_W'(CLUSTER_MAX))
        |=> (reject_cnt_o == $past(reject_cnt_o) + CNT_W'(1)) && $stable(accept_cnt_o));

    p_permit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (live && own_slot_i && accept_cnt_o > reject_cnt_o)
        |=> send_ok_o && !frozen_o && accept_cnt_o == CNT_W'(1) && reject_cnt_o == '0);

    p_freeze_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (live && own_slot_i && accept_cnt_o <= reject_cnt_o)
        |=> frozen_o && !send_ok_o && $stable(accept_cnt_o) && $stable(reject_cnt_o));

    p_frozen_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (frozen_o && !restart_i)
        |=> frozen_o && !send_ok_o && $stable(accept_cnt_o) && $stable(reject_cnt_o));

    p_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        restart_i |=> !frozen_o && !send_ok_o && accept_cnt_o == CNT_W'(1) && reject_cnt_o == '0);

    p_single_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        send_ok_o |=> !send_ok_o || $past(own_slot_i));

endmodule

// File: tb/test_clique_guard.sv
module test_clique_guard;

    localparam int MAXC = 6;
    localparam int W    = $clog2(MAXC + 1);

    logic         clk = 1'b0;
    logic         rst_n;
    logic         restart, slot, own;
    logic [1:0]   res;
    logic         ok, frz;
    logic [W-1:0] acc, rej;

    int total = 0;
    int bad   = 0;
    int m_acc = 1;
    int m_rej = 0;
    bit m_frz = 1'b0;
    bit m_ok  = 1'b0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    clique_guard #(.CLUSTER_MAX(MAXC)) i_clique_guard (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .restart_i    (restart),
        .slot_i       (slot),
        .own_slot_i   (own),
        .result_i     (res),
        .send_ok_o    (ok),
        .frozen_o     (frz),
        .accept_cnt_o (acc),
        .reject_cnt_o (rej)
    );

    task automatic check(string tag);
        total++;
        if (ok !== m_ok || frz !== m_frz || acc !== W'(m_acc) || rej !== W'(m_rej)) begin
            bad++;
            $display("FAIL %s: got ok=%0b frz=%0b acc=%0d rej=%0d, expected ok=%0b frz=%0b acc=%0d rej=%0d",
                     tag, ok, frz, acc, rej, m_ok, m_frz, m_acc, m_rej);
        end
    endtask

    function automatic string tag_of(bit r, bit s, bit o, logic [1:0] rs);
        if (r) return "R9";
        if (m_frz) return "R8";
        if (o && s) return "R10";
        if (o) return (m_acc > m_rej) ? "R6" : "R7";
        if (s && rs == 2'b01) return (m_acc >= MAXC) ? "R5" : "R2";
        if (s && rs == 2'b10) return (m_rej >= MAXC) ? "R5" : "R3";
        return "R4";
    endfunction

    // drive at a falling edge, model the rising edge, check at the next falling edge
    task automatic step(bit r, bit s, bit o, logic [1:0] rs);
        string t;
        t       = tag_of(r, s, o, rs);
        restart = r;
        slot    = s;
        own     = o;
        res     = rs;
        @(posedge clk);
        m_ok = 1'b0;
        if (r) begin
            m_frz = 1'b0;
            m_acc = 1;
            m_rej = 0;
        end else if (!m_frz) begin
            if (o) begin
                if (m_acc > m_rej) begin
                    m_ok  = 1'b1;
                    m_acc = 1;
                    m_rej = 0;
                end else begin
                    m_frz = 1'b1;
                end
            end else if (s) begin
                if (rs == 2'b01 && m_acc < MAXC) m_acc++;
                else if (rs == 2'b10 && m_rej < MAXC) m_rej++;
            end
        end
        @(negedge clk);
        check(t);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n   = 1'b0;
        restart = 1'b0;
        slot    = 1'b0;
        own     = 1'b0;
        res     = 2'b00;
        repeat (3) @(negedge clk);
        check("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1");

        // R2 then R5: climb past the ceiling
        for (int i = 0; i < MAXC + 2; i++) step(0, 1, 0, 2'b01);
        // R4: no-frame codes and idle cycles
        step(0, 1, 0, 2'b00);
        step(0, 1, 0, 2'b11);
        step(0, 0, 0, 2'b01);
        // R6: majority, fresh round
        step(0, 0, 1, 2'b00);
        step(0, 0, 0, 2'b00);
        // R3 then R10: tie plus a carried agreement must still freeze
        step(0, 1, 0, 2'b10);
        step(0, 1, 1, 2'b01);
        // R8: frozen node ignores everything
        step(0, 1, 0, 2'b01);
        step(0, 0, 1, 2'b00);
        step(0, 1, 0, 2'b10);
        // R9: restart overrides a same-cycle own slot
        step(1, 0, 1, 2'b00);
        // R10: a carried disagreement must not spoil a win
        step(0, 1, 0, 2'b01);
        step(0, 1, 1, 2'b10);
        // R3 then R5 on the disagree side, R7 freeze
        for (int i = 0; i < MAXC + 1; i++) step(0, 1, 0, 2'b10);
        step(0, 0, 1, 2'b00);
        step(1, 0, 0, 2'b00);

        void'($urandom(32'd1337));
        for (int i = 0; i < 4000; i++) begin
            bit r, s, o;
            logic [1:0] rs;
            r  = ($urandom % 50) == 0;
            o  = ($urandom % 7) == 0;
            s  = ($urandom % 4) != 0;
            rs = 2'($urandom % 4);
            step(r, s, o, rs);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule